// File: doc/BRIEF.md
# Spare-Block Data Steering for a Cache RAM Slice

This block is the data-steering logic of one cache RAM slice. The slice holds four primary storage blocks, each 16 bits wide and 32 rows deep, and one spare block of the same size. A configuration register is loaded while reset is asserted. It can mark one primary block as unusable, and the spare then takes that block's place on every access. The stand-in does not show at the ports: the next memory level and the CPU see one 64-bit-wide, 32-row memory whatever the configuration.

The slice has two access paths. The wide path moves a full 64-bit row in one access. Logical lane `b` is bits `[16b+15:16b]`. The narrow path moves one 4-bit nibble. It first picks one of four nibbles inside a block, then picks the block from five candidates: the four primaries and the spare. Each block's write input chooses between wide and narrow write data. The spare's write input chooses among the four lane buses. On wide reads, every output bit chooses between its primary block and the spare. The storage blocks are behavioural arrays.

Top module: `spare_steer_slice`

## Requirements
- R1: When reset ends, `wide_rdata_o` and `nib_rdata_o` are both zero.
- R2: Wide write and read behaviour:
  - A wide write stores all 64 bits of `wide_wdata_i` at row `wide_addr_i`.
  - A wide read of that row returns those 64 bits on `wide_rdata_o` from the clock edge that accepts the read.
  - The value holds until the next accepted wide read.
- R3: The narrow address `nib_addr_i` is split into three fields:
  - bits [8:4] give the row;
  - bits [3:2] give the logical lane;
  - bits [1:0] give the nibble inside the lane.

  Taken together, bits [3:0] form an index `i`. A narrow read returns wide bits `[4i+3:4i]` of that row on `nib_rdata_o`, one edge after the request.
- R4: A narrow write replaces only the addressed nibble of the addressed row. The other 60 bits of that row keep their values.
- R5: With the spare enabled for lane `k`, wide and narrow reads and writes behave at the ports exactly as they do with no block marked.
- R6: While the spare stands in for lane `k`, primary block `k` is never written.
- R7: While no block is marked, the spare block is never written.
- R8: Configuration loading:
  - The configuration is sampled at each clock edge while `rst_n` is low.
  - With `cfg_load_i` high, the spare is enabled per `cfg_spare_en_i` and assigned to lane `cfg_bad_blk_i`.
  - With `cfg_load_i` low, the configuration clears to "no block marked".
  - While `rst_n` is high, the configuration inputs have no effect.
- R9: When `wide_en_i` and `nib_en_i` are both high, the wide access is performed. The narrow access is dropped: nothing is written and `nib_rdata_o` keeps its value.
- R10: A write on either path leaves both read outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_load_i | input | 1 | Configuration capture enable, used only during reset |
| cfg_spare_en_i | input | 1 | Spare takes over a lane when captured high |
| cfg_bad_blk_i | input | 2 | Lane whose primary block the spare replaces |
| wide_en_i | input | 1 | Wide access request |
| wide_we_i | input | 1 | Wide access is a write (1) or a read (0) |
| wide_addr_i | input | 5 | Wide access row |
| wide_wdata_i | input | 64 | Wide write data |
| wide_rdata_o | output | 64 | Registered wide read data |
| nib_en_i | input | 1 | Narrow access request |
| nib_we_i | input | 1 | Narrow access is a write (1) or a read (0) |
| nib_addr_i | input | 9 | Row, lane and nibble of the narrow access |
| nib_wdata_i | input | 4 | Narrow write data |
| nib_rdata_o | output | 4 | Registered narrow read data |

## Verification
Both read outputs are loaded at the rising edge that accepts a read. The bench therefore drives each request at a falling edge, withdraws it at the next falling edge, and samples the output right there, one edge after the request. A write also takes effect at the edge that accepts it, so a read issued in the following cycle must already return the new data. The bench checks this for every write-then-read pair. Storage is not cleared by reset, and the configuration is captured on the last reset edge. This lets the bench change the configuration between phases and then read back the contents of the spare block and of the marked block, which shows through the normal ports which of them were left untouched.

// File: rtl/spst_pkg.sv
package spst_pkg;

    localparam int unsigned SPST_BLK_W = 16;
    localparam int unsigned SPST_ROWS  = 32;
    localparam int unsigned SPST_NBLK  = 4;
    localparam int unsigned SPST_NIB_W = 4;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_WIDE_RD,
        ACC_WIDE_WR,
        ACC_NIB_RD,
        ACC_NIB_WR
    } acc_e;

endpackage

// File: rtl/ss_blk_ram.sv
module ss_blk_ram #(
    parameter int unsigned BLK_W = 16,
    parameter int unsigned ROWS  = 32,
    parameter int unsigned NIB_W = 4
) (
    input  logic                      clk,
    input  logic [BLK_W/NIB_W-1:0]    mask,
    input  logic [$clog2(ROWS)-1:0]   addr,
    input  logic [BLK_W-1:0]          wdata,
    output logic [BLK_W-1:0]          rdata
);
    localparam int unsigned NPB = BLK_W / NIB_W;

    logic [BLK_W-1:0] mem [ROWS];

    // nibble-granular write, asynchronous read
    always_ff @(posedge clk) begin
        for (int k = 0; k < NPB; k++) begin
            if (mask[k]) begin
                mem[addr][k*NIB_W +: NIB_W] <= wdata[k*NIB_W +: NIB_W];
            end
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/ss_wr_steer.sv
module ss_wr_steer #(
    parameter int unsigned NBLK  = 4,
    parameter int unsigned BLK_W = 16,
    parameter int unsigned NIB_W = 4
) (
    input  logic                                   wide_wr,
    input  logic                                   nib_wr,
    input  logic [BLK_W*NBLK-1:0]                  wide_wdata,
    input  logic [NIB_W-1:0]                       nib_wdata,
    input  logic [$clog2(NBLK)-1:0]                nib_blk,
    input  logic [$clog2(BLK_W/NIB_W)-1:0]         nib_pos,
    input  logic                                   spare_en,
    input  logic [$clog2(NBLK)-1:0]                bad_blk,
    output logic [NBLK:0][BLK_W-1:0]               phys_wdata,
    output logic [NBLK:0][BLK_W/NIB_W-1:0]         phys_mask
);
    localparam int unsigned NPB    = BLK_W / NIB_W;
    localparam int unsigned BSEL_W = $clog2(NBLK);

    logic [BLK_W-1:0] lane_data [NBLK];
    logic [NPB-1:0]   lane_mask [NBLK];

    // logical lane buses: wide slice or replicated nibble
    always_comb begin
        for (int b = 0; b < NBLK; b++) begin
            if (wide_wr) begin
                lane_data[b] = wide_wdata[b*BLK_W +: BLK_W];
                lane_mask[b] = '1;
            end else begin
                lane_data[b] = {NPB{nib_wdata}};
                lane_mask[b] = (nib_wr && nib_blk == BSEL_W'(b)) ? (NPB'(1) << nib_pos) : '0;
            end
        end
    end

    // primaries take their own lane unless replaced; spare picks one of four lanes
    always_comb begin
        for (int p = 0; p < NBLK; p++) begin
            phys_wdata[p] = lane_data[p];
            phys_mask[p]  = (spare_en && bad_blk == BSEL_W'(p)) ? '0 : lane_mask[p];
        end
        phys_wdata[NBLK] = lane_data[bad_blk];
        phys_mask[NBLK]  = spare_en ? lane_mask[bad_blk] : '0;
    end

endmodule

// File: rtl/ss_rd_steer.sv
module ss_rd_steer #(
    parameter int unsigned NBLK  = 4,
    parameter int unsigned BLK_W = 16,
    parameter int unsigned NIB_W = 4
) (
    input  logic [NBLK:0][BLK_W-1:0]               phys_rdata,
    input  logic                                   spare_en,
    input  logic [$clog2(NBLK)-1:0]                bad_blk,
    input  logic [$clog2(NBLK)-1:0]                nib_blk,
    input  logic [$clog2(BLK_W/NIB_W)-1:0]         nib_pos,
    output logic [BLK_W*NBLK-1:0]                  wide_data,
    output logic [NIB_W-1:0]                       nib_data
);
    localparam int unsigned NPHYS  = NBLK + 1;
    localparam int unsigned BSEL_W = $clog2(NBLK);
    localparam int unsigned PSEL_W = $clog2(NPHYS);

    logic [NIB_W-1:0]  pick [NPHYS];
    logic [PSEL_W-1:0] src;

    // two-input select per wide output lane
    always_comb begin
        for (int b = 0; b < NBLK; b++) begin
            wide_data[b*BLK_W +: BLK_W] =
                (spare_en && bad_blk == BSEL_W'(b)) ? phys_rdata[NBLK] : phys_rdata[b];
        end
    end

    // narrow: nibble inside every block first, then one of five blocks
    always_comb begin
        for (int p = 0; p < NPHYS; p++) begin
            pick[p] = phys_rdata[p][nib_pos*NIB_W +: NIB_W];
        end
        src      = (spare_en && bad_blk == nib_blk) ? PSEL_W'(NBLK) : PSEL_W'(nib_blk);
        nib_data = pick[src];
    end

endmodule

// File: rtl/spare_steer_slice.sv
module spare_steer_slice
    import spst_pkg::*;
#(
    parameter int unsigned BLK_W = SPST_BLK_W,
    parameter int unsigned ROWS  = SPST_ROWS,
    parameter int unsigned NBLK  = SPST_NBLK,
    parameter int unsigned NIB_W = SPST_NIB_W
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cfg_load_i,
    input  logic                                   cfg_spare_en_i,
    input  logic [$clog2(NBLK)-1:0]                cfg_bad_blk_i,
    input  logic                                   wide_en_i,
    input  logic                                   wide_we_i,
    input  logic [$clog2(ROWS)-1:0]                wide_addr_i,
    input  logic [BLK_W*NBLK-1:0]                  wide_wdata_i,
    output logic [BLK_W*NBLK-1:0]                  wide_rdata_o,
    input  logic                                   nib_en_i,
    input  logic                                   nib_we_i,
    input  logic [$clog2(ROWS)+$clog2(NBLK)+$clog2(BLK_W/NIB_W)-1:0] nib_addr_i,
    input  logic [NIB_W-1:0]                       nib_wdata_i,
    output logic [NIB_W-1:0]                       nib_rdata_o
);
    localparam int unsigned AW     = $clog2(ROWS);
    localparam int unsigned WIDE_W = BLK_W * NBLK;
    localparam int unsigned NPB    = BLK_W / NIB_W;
    localparam int unsigned NPB_W  = $clog2(NPB);
    localparam int unsigned BSEL_W = $clog2(NBLK);
    localparam int unsigned NIB_AW = AW + BSEL_W + NPB_W;
    localparam int unsigned NPHYS  = NBLK + 1;

    typedef struct packed {
        logic              spare_en;
        logic [BSEL_W-1:0] bad;
        logic [WIDE_W-1:0] wide_rd;
        logic [NIB_W-1:0]  nib_rd;
    } st_t;

    st_t st_d, st_q;

    acc_e                           acc;
    logic [AW-1:0]                  nib_row;
    logic [BSEL_W-1:0]              nib_blk;
    logic [NPB_W-1:0]               nib_pos;
    logic [AW-1:0]                  row;
    logic [NPHYS-1:0][BLK_W-1:0]    phys_wdata;
    logic [NPHYS-1:0][NPB-1:0]      phys_mask;
    logic [NPHYS-1:0][BLK_W-1:0]    phys_rdata;
    logic [WIDE_W-1:0]              rd_wide;
    logic [NIB_W-1:0]               rd_nib;

    assign nib_row = nib_addr_i[NIB_AW-1 -: AW];
    assign nib_blk = nib_addr_i[NPB_W +: BSEL_W];
    assign nib_pos = nib_addr_i[NPB_W-1:0];

    // arbitration: wide wins, nothing happens during reset
    always_comb begin
        acc = ACC_IDLE;
        if (rst_n) begin
            if (wide_en_i) begin
                acc = wide_we_i ? ACC_WIDE_WR : ACC_WIDE_RD;
            end else if (nib_en_i) begin
                acc = nib_we_i ? ACC_NIB_WR : ACC_NIB_RD;
            end
        end
    end

    assign row = (acc == ACC_NIB_RD || acc == ACC_NIB_WR) ? nib_row : wide_addr_i;

    ss_wr_steer #(.NBLK(NBLK), .BLK_W(BLK_W), .NIB_W(NIB_W)) u_wr (
        .wide_wr    (acc == ACC_WIDE_WR),
        .nib_wr     (acc == ACC_NIB_WR),
        .wide_wdata (wide_wdata_i),
        .nib_wdata  (nib_wdata_i),
        .nib_blk    (nib_blk),
        .nib_pos    (nib_pos),
        .spare_en   (st_q.spare_en),
        .bad_blk    (st_q.bad),
        .phys_wdata (phys_wdata),
        .phys_mask  (phys_mask)
    );

    for (genvar p = 0; p < NPHYS; p++) begin : g_blk
        ss_blk_ram #(.BLK_W(BLK_W), .ROWS(ROWS), .NIB_W(NIB_W)) u_ram (
            .clk   (clk),
            .mask  (phys_mask[p]),
            .addr  (row),
            .wdata (phys_wdata[p]),
            .rdata (phys_rdata[p])
        );
    end

    ss_rd_steer #(.NBLK(NBLK), .BLK_W(BLK_W), .NIB_W(NIB_W)) u_rd (
        .phys_rdata (phys_rdata),
        .spare_en   (st_q.spare_en),
        .bad_blk    (st_q.bad),
        .nib_blk    (nib_blk),
        .nib_pos    (nib_pos),
        .wide_data  (rd_wide),
        .nib_data   (rd_nib)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.wide_rd  = '0;
            st_d.nib_rd   = '0;
            st_d.spare_en = cfg_load_i ? cfg_spare_en_i : 1'b0;
            st_d.bad      = cfg_load_i ? cfg_bad_blk_i : '0;
        end else begin
            if (acc == ACC_WIDE_RD) st_d.wide_rd = rd_wide;
            if (acc == ACC_NIB_RD)  st_d.nib_rd  = rd_nib;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wide_rdata_o = st_q.wide_rd;
    assign nib_rdata_o  = st_q.nib_rd;

endmodule

// File: rtl/ss_checker.sv
module ss_checker #(
    parameter int unsigned NBLK   = 4,
    parameter int unsigned NPB    = 4,
    parameter int unsigned WIDE_W = 64,
    parameter int unsigned NIB_W  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wide_en,
    input logic                      wide_we,
    input logic                      nib_en,
    input logic                      nib_we,
    input logic [WIDE_W-1:0]         wide_rdata,
    input logic [NIB_W-1:0]          nib_rdata,
    input logic                      spare_en_q,
    input logic [$clog2(NBLK)-1:0]   bad_q,
    input logic [(NBLK+1)*NPB-1:0]   phys_mask
);

    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($stable(spare_en_q) && $stable(bad_q)));

    p_wr_keeps_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_en && wide_we) |=> ($stable(wide_rdata) && $stable(nib_rdata)));

    p_narrow_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_en && nib_en) |=> $stable(nib_rdata));

    p_single_nibble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_en && nib_we && !wide_en) |-> ($countones(phys_mask) == 1));

    p_spare_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !spare_en_q |-> (phys_mask[NBLK*NPB +: NPB] == '0));

    p_bad_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spare_en_q |-> (phys_mask[bad_q*NPB +: NPB] == '0));

endmodule

bind spare_steer_slice ss_checker #(
    .NBLK(NBLK), .NPB(NPB), .WIDE_W(WIDE_W), .NIB_W(NIB_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide_en    (wide_en_i),
    .wide_we    (wide_we_i),
    .nib_en     (nib_en_i),
    .nib_we     (nib_we_i),
    .wide_rdata (wide_rdata_o),
    .nib_rdata  (nib_rdata_o),
    .spare_en_q (st_q.spare_en),
    .bad_q      (st_q.bad),
    .phys_mask  (phys_mask)
);

// File: tb/sim_spare_steer_slice.sv
module sim_spare_steer_slice;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load_i = 1'b0, cfg_spare_en_i = 1'b0;
    logic [1:0]  cfg_bad_blk_i = '0;
    logic        wide_en_i = 1'b0, wide_we_i = 1'b0;
    logic [4:0]  wide_addr_i = '0;
    logic [63:0] wide_wdata_i = '0;
    logic [63:0] wide_rdata_o;
    logic        nib_en_i = 1'b0, nib_we_i = 1'b0;
    logic [8:0]  nib_addr_i = '0;
    logic [3:0]  nib_wdata_i = '0;
    logic [3:0]  nib_rdata_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    spare_steer_slice u0 (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic ld, input logic en, input logic [1:0] bad);
        @(negedge clk);
        rst_n = 1'b0; cfg_load_i = ld; cfg_spare_en_i = en; cfg_bad_blk_i = bad;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; cfg_load_i = 1'b0; cfg_spare_en_i = 1'b0; cfg_bad_blk_i = '0;
    endtask

    task automatic wide_wr(input logic [4:0] r, input logic [63:0] d);
        wide_en_i = 1'b1; wide_we_i = 1'b1; wide_addr_i = r; wide_wdata_i = d;
        @(negedge clk);
        wide_en_i = 1'b0; wide_we_i = 1'b0;
    endtask

    task automatic wide_rd(input logic [4:0] r, output logic [63:0] d);
        wide_en_i = 1'b1; wide_we_i = 1'b0; wide_addr_i = r;
        @(negedge clk);
        wide_en_i = 1'b0;
        d = wide_rdata_o;
    endtask

    task automatic nib_wr(input logic [8:0] a, input logic [3:0] v);
        nib_en_i = 1'b1; nib_we_i = 1'b1; nib_addr_i = a; nib_wdata_i = v;
        @(negedge clk);
        nib_en_i = 1'b0; nib_we_i = 1'b0;
    endtask

    task automatic nib_rd(input logic [8:0] a, output logic [3:0] v);
        nib_en_i = 1'b1; nib_we_i = 1'b0; nib_addr_i = a;
        @(negedge clk);
        nib_en_i = 1'b0;
        v = nib_rdata_o;
    endtask

    task automatic both_wr(input logic [4:0] r, input logic [63:0] d,
                           input logic nwe, input logic [8:0] a, input logic [3:0] v);
        wide_en_i = 1'b1; wide_we_i = 1'b1; wide_addr_i = r; wide_wdata_i = d;
        nib_en_i = 1'b1; nib_we_i = nwe; nib_addr_i = a; nib_wdata_i = v;
        @(negedge clk);
        wide_en_i = 1'b0; wide_we_i = 1'b0; nib_en_i = 1'b0; nib_we_i = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b0, 1'b0, 2'd0);
        chk("R1 wide after reset", wide_rdata_o, 64'd0);
        chk("R1 nibble after reset", {60'd0, nib_rdata_o}, 64'd0);
    endtask

    task automatic t_wide();
        logic [63:0] d;
        wide_wr(5'd0,  64'h0F1E_2D3C_4B5A_6978);
        wide_wr(5'd17, 64'hDEAD_BEEF_CAFE_F00D);
        wide_wr(5'd31, 64'h8000_0000_0000_0001);
        wide_rd(5'd0, d);  chk("R2 row 0", d, 64'h0F1E_2D3C_4B5A_6978);
        wide_rd(5'd17, d); chk("R2 row 17", d, 64'hDEAD_BEEF_CAFE_F00D);
        wide_rd(5'd31, d); chk("R2 row 31", d, 64'h8000_0000_0000_0001);
        wide_wr(5'd0, 64'h1);
        chk("R10 wide out after write", wide_rdata_o, 64'h8000_0000_0000_0001);
        nib_wr({5'd0, 4'd0}, 4'h7);
        chk("R10 wide out after nibble write", wide_rdata_o, 64'h8000_0000_0000_0001);
        wide_rd(5'd0, d); chk("R4 nibble 0 of row 0", d, 64'h7);
    endtask

    task automatic t_nib_map();
        logic [63:0] row3 = 64'h0123_4567_89AB_CDEF;
        logic [3:0] v;
        wide_wr(5'd3, row3);
        for (int i = 0; i < 16; i++) begin
            nib_rd({5'd3, 4'(i)}, v);
            chk("R3 nibble index map", {60'd0, v}, {60'd0, row3[4*i +: 4]});
        end
    endtask

    task automatic t_nib_write();
        logic [63:0] d;
        logic [3:0] v;
        nib_wr({5'd3, 4'd6}, 4'hF);
        chk("R10 nibble out after write", {60'd0, nib_rdata_o}, 64'h0);
        wide_rd(5'd3, d);
        chk("R4 only nibble 6 changed", d, 64'h0123_4567_8FAB_CDEF);
        nib_rd({5'd3, 4'd6}, v);
        chk("R3 nibble readback", {60'd0, v}, 64'hF);
    endtask

    task automatic t_priority();
        logic [63:0] d;
        logic [3:0] v;
        nib_rd({5'd3, 4'd0}, v);
        chk("R3 nibble 0 of row 3", {60'd0, v}, 64'hF);
        both_wr(5'd7, 64'h5555_AAAA_5555_AAAA, 1'b0, {5'd3, 4'd1}, 4'h0);
        chk("R9 narrow read dropped", {60'd0, nib_rdata_o}, 64'hF);
        wide_wr(5'd9, 64'd0);
        both_wr(5'd8, 64'h0C0C_0C0C_0C0C_0C0C, 1'b1, {5'd9, 4'd0}, 4'h3);
        wide_rd(5'd9, d); chk("R9 narrow write dropped", d, 64'd0);
        wide_rd(5'd8, d); chk("R9 wide write done", d, 64'h0C0C_0C0C_0C0C_0C0C);
        wide_rd(5'd7, d); chk("R9 wide write with narrow read", d, 64'h5555_AAAA_5555_AAAA);
    endtask

    task automatic t_spare_flow();
        logic [63:0] d;
        logic [3:0] v;
        wide_wr(5'd10, 64'hA0A0_B0B0_C0C0_D0D0);
        do_reset(1'b1, 1'b1, 2'd1);
        wide_wr(5'd10, 64'h1234_5678_9ABC_DEF0);
        wide_rd(5'd10, d); chk("R5 wide via spare", d, 64'h1234_5678_9ABC_DEF0);
        nib_rd({5'd10, 2'd1, 2'd2}, v);
        chk("R5 nibble via spare", {60'd0, v}, 64'hA);
        nib_wr({5'd10, 2'd1, 2'd0}, 4'h5);
        wide_rd(5'd10, d); chk("R5 nibble write via spare", d, 64'h1234_5678_9AB5_DEF0);
        cfg_load_i = 1'b1; cfg_spare_en_i = 1'b0; cfg_bad_blk_i = 2'd3;
        repeat (3) @(negedge clk);
        cfg_load_i = 1'b0; cfg_bad_blk_i = 2'd0;
        wide_rd(5'd10, d); chk("R8 cfg ignored out of reset", d, 64'h1234_5678_9AB5_DEF0);
        do_reset(1'b0, 1'b1, 2'd1);
        wide_rd(5'd10, d); chk("R6 marked block untouched", d, 64'h1234_5678_C0C0_DEF0);
        chk("R8 no load clears spare", {63'd0, d[16]}, 64'd0);
        wide_wr(5'd10, 64'hFEDC_BA98_7654_3210);
        do_reset(1'b1, 1'b1, 2'd1);
        wide_rd(5'd10, d); chk("R7 spare untouched when idle", d, 64'hFEDC_BA98_9AB5_3210);
    endtask

    initial begin
        t_reset();
        t_wide();
        t_nib_map();
        t_nib_write();
        t_priority();
        t_spare_flow();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule